// File: doc/BRIEF.md
# PCIe Legacy and Message Interrupt Aggregator

This block gathers the interrupt sources seen by a PCIe root complex and turns them into one interrupt line for the CPU. Four legacy wire-interrupt lines (A to D) report assert and deassert events. A power-state change and a flush event come from the link layer. Message-signalled interrupts (MSI) arrive as a write strobe that carries a vector number and a data byte. Every source lands in a sticky status register that is cleared by writing 1. Each status register has a mask register beside it.

The sources form a cascade. Unmasked primary status bits, which include the MSI-pending bit, raise a core bit in a central status register. Unmasked secondary bits raise a second central bit. Unmasked central bits, registered once more, drive `irq_o`. Software reads any register over a combinational read port. It writes masks and clears status over a one-cycle write port. Writes take effect at the next clock edge.

Register select codes are `0` primary status, `1` primary mask, `2` secondary status, `3` secondary mask, `4` MSI status, `5` MSI mask, `6` MSI data, `7` central status and `8` central mask. Codes 9 to 15 are unused.

Top module: `pcie_irq_aggr`

## Requirements
- R1: One clock edge after a pulse on `intx_assert_i[i]`, primary status bit 16+i reads 1. One edge after a pulse on `intx_deassert_i[i]`, bit 20+i reads 1 (i = 0..3).
- R2: One edge after an MSI write strobe with vector v, MSI status bit v reads 1. The MSI data register (code 6) then reads the strobe's data byte in bits [7:0] and zero in all higher bits.
- R3: Primary status bit 24 (MSI pending) sets on an MSI write only when MSI mask bit v is 0. A masked vector still sets its MSI status bit.
- R4: One edge after a power-state pulse, secondary status bit 4 reads 1. One edge after a flush pulse, secondary status bit 5 reads 1.
- R5: A write to a status register (codes 0, 2, 4, 7) clears each bit where the write data is 1 and leaves the bits where it is 0. Status bits never clear in any other way.
- R6: When a source event and a clearing write hit the same status bit at the same edge, the bit stays set.
- R7: A mask bit of 1 removes its status bit from the summary. Central status bit 16 latches when any unmasked primary status bit is set. Central bit 19 latches when any unmasked secondary status bit is set. Either bit appears one edge after the lower status bit.
- R8: `irq_o` equals, one edge later, the OR of central status bits whose central mask bit is 0.
- R9: After reset, all status registers, the MSI data register and `irq_o` are 0. The masks read all-ones over their valid bits: primary 0x7FFFFFF, secondary 0x30, MSI 0xFFFFFFFF, central 0xFFF0FB.
- R10: Mask registers keep only their valid bits. Reads of unused codes return 0. Writes to unused codes, and to the MSI data register, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intx_assert_i | input | 4 | Legacy line assert event pulses, line A at bit 0 |
| intx_deassert_i | input | 4 | Legacy line deassert event pulses |
| pm_change_i | input | 1 | Power-state change event pulse |
| flush_i | input | 1 | Flush event pulse |
| msi_wr_i | input | 1 | Inbound MSI write strobe |
| msi_vec_i | input | 5 | MSI vector number |
| msi_data_i | input | 8 | MSI data byte |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 4 | Register select for writes |
| reg_wdata_i | input | 32 | Write data (1 clears status bits, or new mask value) |
| reg_raddr_i | input | 4 | Register select for reads |
| reg_rdata_o | output | 32 | Read data, combinational from the read select |
| irq_o | output | 1 | Interrupt to the CPU |

## Verification
Every status bit and the MSI data register are visible on the read port one edge after their event or write. Central status follows one edge after the lower status. `irq_o` follows one edge after that. The bench drives inputs at the falling edge and reads back just after it. It checks the intermediate cycles of the cascade one by one, so a result that arrives one edge early or late is reported as a miscompare. The sweeps cover every legacy line, every MSI vector and the mask combinations of the cascade.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned SEL_W     = 4;
    localparam int unsigned NUM_LINES = 4;

    // primary status layout
    localparam int unsigned CORE_W       = 27;
    localparam int unsigned CORE_ASSERT  = 16;
    localparam int unsigned CORE_DEASRT  = 20;
    localparam int unsigned CORE_MSI_BIT = 24;
    localparam logic [CORE_W-1:0] CORE_VALID = '1;

    // secondary status layout
    localparam int unsigned AUX_W       = 6;
    localparam int unsigned AUX_PM_BIT  = 4;
    localparam int unsigned AUX_FL_BIT  = 5;
    localparam logic [AUX_W-1:0] AUX_VALID = 6'h30;

    // central status layout
    localparam int unsigned TOP_W        = 24;
    localparam int unsigned TOP_CORE_BIT = 16;
    localparam int unsigned TOP_AUX_BIT  = 19;
    localparam logic [TOP_W-1:0] TOP_VALID = 24'hFFF0FB;

    typedef enum logic [SEL_W-1:0] {
        SEL_CORE_STAT = 4'd0,
        SEL_CORE_MASK = 4'd1,
        SEL_AUX_STAT  = 4'd2,
        SEL_AUX_MASK  = 4'd3,
        SEL_VEC_STAT  = 4'd4,
        SEL_VEC_MASK  = 4'd5,
        SEL_VEC_DATA  = 4'd6,
        SEL_TOP_STAT  = 4'd7,
        SEL_TOP_MASK  = 4'd8
    } reg_sel_e;

endpackage

// File: rtl/irq_stat_bank.sv
// Sticky status register with write-1-to-clear and a matching mask register.
module irq_stat_bank #(
    parameter int unsigned   W        = 8,
    parameter logic [W-1:0]  VALID    = '1,
    parameter logic [W-1:0]  MASK_RST = VALID
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);

    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clr_we_i) begin
            bank_d.stat = bank_q.stat & ~wdata_i;
        end
        // a new event wins over a clear at the same edge
        bank_d.stat = (bank_d.stat | set_i) & VALID;
        if (mask_we_i) begin
            bank_d.mask = wdata_i & VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.stat <= '0;
            bank_q.mask <= MASK_RST & VALID;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_o = bank_q.stat;
    assign mask_o = bank_q.mask;
    assign pend_o = |(bank_q.stat & ~bank_q.mask);

endmodule

// File: rtl/pcie_irq_aggr.sv
module pcie_irq_aggr
    import pcie_irq_pkg::*;
#(
    parameter int unsigned NUM_VEC   = 32,
    parameter int unsigned PAYLOAD_W = 8,
    localparam int unsigned VEC_IDX_W = $clog2(NUM_VEC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           intx_assert_i,
    input  logic [3:0]           intx_deassert_i,
    input  logic                 pm_change_i,
    input  logic                 flush_i,
    input  logic                 msi_wr_i,
    input  logic [VEC_IDX_W-1:0] msi_vec_i,
    input  logic [PAYLOAD_W-1:0] msi_data_i,
    input  logic                 reg_we_i,
    input  logic [3:0]           reg_waddr_i,
    input  logic [31:0]          reg_wdata_i,
    input  logic [3:0]           reg_raddr_i,
    output logic [31:0]          reg_rdata_o,
    output logic                 irq_o
);

    typedef struct packed {
        logic [PAYLOAD_W-1:0] pay;
        logic                 irq;
    } out_regs_t;

    out_regs_t out_d, out_q;

    logic [CORE_W-1:0]  core_set, core_stat, core_mask;
    logic [AUX_W-1:0]   aux_set, aux_stat, aux_mask;
    logic [NUM_VEC-1:0] vec_set, vec_stat, vec_mask;
    logic [TOP_W-1:0]   top_set, top_stat, top_mask;
    logic               core_pend, aux_pend, vec_pend, top_pend;
    logic [8:0]         wsel;
    reg_sel_e           wsel_e, rsel_e;

    assign wsel_e = reg_sel_e'(reg_waddr_i);
    assign rsel_e = reg_sel_e'(reg_raddr_i);

    // one write strobe per register select code
    always_comb begin
        wsel = '0;
        if (reg_we_i) begin
            case (wsel_e)
                SEL_CORE_STAT: wsel[0] = 1'b1;
                SEL_CORE_MASK: wsel[1] = 1'b1;
                SEL_AUX_STAT:  wsel[2] = 1'b1;
                SEL_AUX_MASK:  wsel[3] = 1'b1;
                SEL_VEC_STAT:  wsel[4] = 1'b1;
                SEL_VEC_MASK:  wsel[5] = 1'b1;
                SEL_TOP_STAT:  wsel[7] = 1'b1;
                SEL_TOP_MASK:  wsel[8] = 1'b1;
                default:       wsel    = '0;
            endcase
        end
    end

    // event sources into each status bank
    always_comb begin
        core_set = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            core_set[CORE_ASSERT + i] = intx_assert_i[i];
            core_set[CORE_DEASRT + i] = intx_deassert_i[i];
        end
        core_set[CORE_MSI_BIT] = msi_wr_i & ~vec_mask[msi_vec_i];

        aux_set             = '0;
        aux_set[AUX_PM_BIT] = pm_change_i;
        aux_set[AUX_FL_BIT] = flush_i;

        vec_set = '0;
        vec_set[msi_vec_i] = msi_wr_i;

        top_set               = '0;
        top_set[TOP_CORE_BIT] = core_pend;
        top_set[TOP_AUX_BIT]  = aux_pend;
    end

    irq_stat_bank #(.W(CORE_W), .VALID(CORE_VALID)) u_core (
        .clk(clk), .rst_n(rst_n), .set_i(core_set),
        .clr_we_i(wsel[0]), .mask_we_i(wsel[1]), .wdata_i(reg_wdata_i[CORE_W-1:0]),
        .stat_o(core_stat), .mask_o(core_mask), .pend_o(core_pend)
    );

    irq_stat_bank #(.W(AUX_W), .VALID(AUX_VALID)) u_aux (
        .clk(clk), .rst_n(rst_n), .set_i(aux_set),
        .clr_we_i(wsel[2]), .mask_we_i(wsel[3]), .wdata_i(reg_wdata_i[AUX_W-1:0]),
        .stat_o(aux_stat), .mask_o(aux_mask), .pend_o(aux_pend)
    );

    irq_stat_bank #(.W(NUM_VEC)) u_vec (
        .clk(clk), .rst_n(rst_n), .set_i(vec_set),
        .clr_we_i(wsel[4]), .mask_we_i(wsel[5]), .wdata_i(reg_wdata_i[NUM_VEC-1:0]),
        .stat_o(vec_stat), .mask_o(vec_mask), .pend_o(vec_pend)
    );

    irq_stat_bank #(.W(TOP_W), .VALID(TOP_VALID)) u_top (
        .clk(clk), .rst_n(rst_n), .set_i(top_set),
        .clr_we_i(wsel[7]), .mask_we_i(wsel[8]), .wdata_i(reg_wdata_i[TOP_W-1:0]),
        .stat_o(top_stat), .mask_o(top_mask), .pend_o(top_pend)
    );

    // MSI data capture and the registered CPU line
    always_comb begin
        out_d     = out_q;
        out_d.irq = top_pend;
        if (msi_wr_i) begin
            out_d.pay = msi_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (rsel_e)
            SEL_CORE_STAT: reg_rdata_o[CORE_W-1:0]    = core_stat;
            SEL_CORE_MASK: reg_rdata_o[CORE_W-1:0]    = core_mask;
            SEL_AUX_STAT:  reg_rdata_o[AUX_W-1:0]     = aux_stat;
            SEL_AUX_MASK:  reg_rdata_o[AUX_W-1:0]     = aux_mask;
            SEL_VEC_STAT:  reg_rdata_o[NUM_VEC-1:0]   = vec_stat;
            SEL_VEC_MASK:  reg_rdata_o[NUM_VEC-1:0]   = vec_mask;
            SEL_VEC_DATA:  reg_rdata_o[PAYLOAD_W-1:0] = out_q.pay;
            SEL_TOP_STAT:  reg_rdata_o[TOP_W-1:0]     = top_stat;
            SEL_TOP_MASK:  reg_rdata_o[TOP_W-1:0]     = top_mask;
            default:       reg_rdata_o                = '0;
        endcase
    end

    assign irq_o = out_q.irq;

    // the MSI bank pending flag feeds core bit 24 through the set path only
    logic unused_vec_pend;
    assign unused_vec_pend = vec_pend;

endmodule

// File: rtl/pcie_irq_aggr_chk.sv
module pcie_irq_aggr_chk #(
    parameter int unsigned NUM_VEC   = 32,
    parameter int unsigned PAYLOAD_W = 8,
    localparam int unsigned VEC_IDX_W = $clog2(NUM_VEC)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           intx_assert_i,
    input logic [3:0]           intx_deassert_i,
    input logic                 msi_wr_i,
    input logic [VEC_IDX_W-1:0] msi_vec_i,
    input logic [PAYLOAD_W-1:0] msi_data_i,
    input logic                 reg_we_i,
    input logic [3:0]           reg_waddr_i,
    input logic                 irq_o,
    input logic [26:0]          core_stat,
    input logic                 core_pend,
    input logic [NUM_VEC-1:0]   vec_stat,
    input logic [PAYLOAD_W-1:0] pay_q,
    input logic [23:0]          top_stat,
    input logic [23:0]          top_mask
);

    AST_ASSERT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (intx_assert_i != 4'd0) |=> ((core_stat[19:16] & $past(intx_assert_i)) == $past(intx_assert_i))); // R1

    AST_DEASSERT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (intx_deassert_i != 4'd0) |=> ((core_stat[23:20] & $past(intx_deassert_i)) == $past(intx_deassert_i))); // R1

    AST_VEC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        msi_wr_i |=> vec_stat[$past(msi_vec_i)]); // R2

    AST_PAYLOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_wr_i |=> (pay_q == $past(msi_data_i))); // R2

    AST_CORE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_i && reg_waddr_i == 4'd0) |=> ((core_stat & $past(core_stat)) == $past(core_stat))); // R5

    AST_TOP_FOLLOWS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        core_pend |=> top_stat[16]); // R7

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(top_stat & ~top_mask)))); // R8

endmodule

bind pcie_irq_aggr pcie_irq_aggr_chk #(.NUM_VEC(NUM_VEC), .PAYLOAD_W(PAYLOAD_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .intx_assert_i(intx_assert_i), .intx_deassert_i(intx_deassert_i),
    .msi_wr_i(msi_wr_i), .msi_vec_i(msi_vec_i), .msi_data_i(msi_data_i),
    .reg_we_i(reg_we_i), .reg_waddr_i(reg_waddr_i), .irq_o(irq_o),
    .core_stat(core_stat), .core_pend(core_pend), .vec_stat(vec_stat),
    .pay_q(out_q.pay), .top_stat(top_stat), .top_mask(top_mask)
);

// File: tb/test_pcie_irq_aggr.sv
module test_pcie_irq_aggr;

    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] A_CSTAT = 4'd0, A_CMASK = 4'd1, A_ASTAT = 4'd2, A_AMASK = 4'd3;
    localparam logic [3:0] A_VSTAT = 4'd4, A_VMASK = 4'd5, A_VDATA = 4'd6;
    localparam logic [3:0] A_TSTAT = 4'd7, A_TMASK = 4'd8;
    localparam logic [31:0] CORE_ALL = 32'h07FF_FFFF;
    localparam logic [31:0] AUX_ALL  = 32'h0000_0030;
    localparam logic [31:0] TOP_ALL  = 32'h00FF_F0FB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  intx_assert = '0, intx_deassert = '0;
    logic        pm_change = 1'b0, flush = 1'b0;
    logic        msi_wr = 1'b0;
    logic [4:0]  msi_vec = '0;
    logic [7:0]  msi_data = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcie_irq_aggr i_pcie_irq_aggr (
        .clk(clk), .rst_n(rst_n),
        .intx_assert_i(intx_assert), .intx_deassert_i(intx_deassert),
        .pm_change_i(pm_change), .flush_i(flush),
        .msi_wr_i(msi_wr), .msi_vec_i(msi_vec), .msi_data_i(msi_data),
        .reg_we_i(reg_we), .reg_waddr_i(reg_waddr), .reg_wdata_i(reg_wdata),
        .reg_raddr_i(reg_raddr), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", tag, what, got, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
        reg_raddr = a;
        #1;
        chk(tag, $sformatf("reg %0d", a), reg_rdata, exp);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        #1;
        chk(tag, "irq", {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic pulse_intx(input logic [3:0] as, input logic [3:0] de);
        intx_assert = as; intx_deassert = de;
        tick();
        intx_assert = '0; intx_deassert = '0;
    endtask

    task automatic send_msi(input int v, input logic [7:0] d);
        msi_wr = 1'b1; msi_vec = 5'(v); msi_data = d;
        tick();
        msi_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        chk_reg("R9", A_CSTAT, 32'h0);
        chk_reg("R9", A_CMASK, CORE_ALL);
        chk_reg("R9", A_ASTAT, 32'h0);
        chk_reg("R9", A_AMASK, AUX_ALL);
        chk_reg("R9", A_VSTAT, 32'h0);
        chk_reg("R9", A_VMASK, 32'hFFFF_FFFF);
        chk_reg("R9", A_VDATA, 32'h0);
        chk_reg("R9", A_TSTAT, 32'h0);
        chk_reg("R9", A_TMASK, TOP_ALL);
        chk_irq("R9", 1'b0);

        // R1 sweep over every legacy line, R5 single-bit clears
        for (int i = 0; i < 4; i++) begin
            pulse_intx(4'(1 << i), 4'h0);
            chk_reg("R1", A_CSTAT, 32'(1) << (16 + i));
            wr(A_CSTAT, 32'(1) << (16 + i));
            chk_reg("R5", A_CSTAT, 32'h0);
            pulse_intx(4'h0, 4'(1 << i));
            chk_reg("R1", A_CSTAT, 32'(1) << (20 + i));
            wr(A_CSTAT, 32'(1) << (20 + i));
            chk_reg("R5", A_CSTAT, 32'h0);
        end

        // R5 partial and zero writes leave other bits alone
        pulse_intx(4'hF, 4'h0);
        chk_reg("R1", A_CSTAT, 32'h000F_0000);
        wr(A_CSTAT, 32'h0005_0000);
        chk_reg("R5", A_CSTAT, 32'h000A_0000);
        wr(A_CSTAT, 32'h0);
        chk_reg("R5", A_CSTAT, 32'h000A_0000);
        wr(A_CSTAT, CORE_ALL);
        chk_reg("R5", A_CSTAT, 32'h0);

        // R4 secondary sources
        pm_change = 1'b1; tick(); pm_change = 1'b0;
        chk_reg("R4", A_ASTAT, 32'h10);
        flush = 1'b1; tick(); flush = 1'b0;
        chk_reg("R4", A_ASTAT, 32'h30);
        wr(A_ASTAT, 32'h10);
        chk_reg("R5", A_ASTAT, 32'h20);
        wr(A_ASTAT, 32'hFF);
        chk_reg("R5", A_ASTAT, 32'h0);

        // R2/R3 every vector while all vectors are masked
        for (int v = 0; v < 32; v++) begin
            send_msi(v, 8'((v * 29 + 3) & 8'hFF));
            chk_reg("R2", A_VSTAT, 32'(1) << v);
            chk_reg("R2", A_VDATA, 32'((v * 29 + 3) & 8'hFF));
            chk_reg("R3", A_CSTAT, 32'h0);
            wr(A_VSTAT, 32'(1) << v);
        end
        chk_reg("R5", A_VSTAT, 32'h0);

        // R3 low half unmasked
        wr(A_VMASK, 32'hFFFF_0000);
        chk_reg("R3", A_VMASK, 32'hFFFF_0000);
        for (int k = 0; k < 5; k++) begin
            int v;
            v = (k == 0) ? 0 : (k == 1) ? 7 : (k == 2) ? 15 : (k == 3) ? 16 : 31;
            send_msi(v, 8'(8'hA0 + k));
            chk_reg("R3", A_CSTAT, (v < 16) ? 32'h0100_0000 : 32'h0);
            chk_reg("R2", A_VDATA, 32'(8'hA0 + k));
            wr(A_CSTAT, CORE_ALL);
            wr(A_VSTAT, 32'hFFFF_FFFF);
        end

        // R6 event and clear at the same edge
        pulse_intx(4'h4, 4'h0);
        intx_assert = 4'h4;
        wr(A_CSTAT, 32'h0004_0000);
        intx_assert = 4'h0;
        chk_reg("R6", A_CSTAT, 32'h0004_0000);
        wr(A_CSTAT, 32'h0004_0000);
        chk_reg("R6", A_CSTAT, 32'h0);
        send_msi(9, 8'h11);
        msi_wr = 1'b1; msi_vec = 5'd9;
        wr(A_VSTAT, 32'(1) << 9);
        msi_wr = 1'b0;
        chk_reg("R6", A_VSTAT, 32'(1) << 9);
        wr(A_VSTAT, 32'hFFFF_FFFF);
        wr(A_CSTAT, CORE_ALL);

        // R7/R8 cascade timing
        wr(A_TMASK, TOP_ALL & ~32'h0001_0000);
        wr(A_CMASK, CORE_ALL & ~32'h0002_0000);
        pulse_intx(4'h1, 4'h0);
        tick(); tick();
        chk_reg("R7", A_TSTAT, 32'h0);
        chk_irq("R7", 1'b0);
        wr(A_CSTAT, CORE_ALL);
        pulse_intx(4'h2, 4'h0);
        chk_reg("R7", A_TSTAT, 32'h0);
        chk_irq("R8", 1'b0);
        tick();
        chk_reg("R7", A_TSTAT, 32'h0001_0000);
        chk_irq("R8", 1'b0);
        tick();
        chk_irq("R8", 1'b1);
        wr(A_TSTAT, 32'h0001_0000);
        chk_reg("R6", A_TSTAT, 32'h0001_0000);
        wr(A_CSTAT, CORE_ALL);
        wr(A_TSTAT, 32'h0001_0000);
        chk_reg("R5", A_TSTAT, 32'h0);
        chk_irq("R8", 1'b1);
        tick();
        chk_irq("R8", 1'b0);

        // R7/R8 secondary path, every aux mask pattern against both events
        wr(A_TMASK, TOP_ALL & ~32'h0008_0000);
        for (int m = 0; m < 4; m++) begin
            for (int e = 1; e < 4; e++) begin
                logic exp_p;
                exp_p = ((e & ~m) != 0);
                wr(A_AMASK, 32'(m) << 4);
                pm_change = e[0]; flush = e[1];
                tick();
                pm_change = 1'b0; flush = 1'b0;
                chk_reg("R4", A_ASTAT, 32'(e) << 4);
                tick();
                chk_reg("R7", A_TSTAT, exp_p ? 32'h0008_0000 : 32'h0);
                tick();
                chk_irq("R8", exp_p);
                wr(A_ASTAT, AUX_ALL);
                wr(A_TSTAT, TOP_ALL);
                tick();
                chk_irq("R8", 1'b0);
            end
        end

        // R10 valid bits and unused codes
        wr(A_CMASK, 32'hFFFF_FFFF);
        chk_reg("R10", A_CMASK, CORE_ALL);
        wr(A_AMASK, 32'hFFFF_FFFF);
        chk_reg("R10", A_AMASK, AUX_ALL);
        wr(A_TMASK, 32'hFFFF_FFFF);
        chk_reg("R10", A_TMASK, TOP_ALL);
        send_msi(3, 8'h5A);
        wr(A_VDATA, 32'h0000_00FF);
        chk_reg("R10", A_VDATA, 32'h0000_005A);
        for (int a = 9; a < 16; a++) begin
            wr(4'(a), 32'h0);
            chk_reg("R10", 4'(a), 32'h0);
        end
        chk_reg("R10", A_CMASK, CORE_ALL);
        chk_reg("R10", A_VSTAT, 32'h0000_0008);
        chk_reg("R10", A_VMASK, 32'hFFFF_0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule